// File: doc/BRIEF.md
# Eight-bit execute unit with flag-conditioned branches

This block is the execute stage of a small 8-bit RISC core. Each cycle it may accept one operation: a 5-bit opcode, two 8-bit operands, a 3-bit shift or rotate distance and a 6-bit instruction address for control transfers. One clock later it presents the 8-bit result, a write strobe for the register file, the updated status flags (zero, carry, auxiliary carry, even parity), a branch-taken indication with its target, and a halt indication.

The status flags are kept in a register inside the block. Branch conditions read that register, so a branch sees the flags left by earlier operations. Operand fetch, memory access and program counter update stay outside the block; load and store opcodes only carry operand A through to the result port.

Top module: `alu8Exec`

## Requirements
- R1: While reset is low and in the first cycle after it is released, every output is zero, including all four flags.
- R2: outValid is high exactly one cycle after a cycle with inValid high; writeEn is high with it only for the computing opcodes 00000 to 01010 and 10000 to 10101.
- R3: Opcodes 00001 (A+B), 00010 (A-B), 00101 (A+1) and 00110 (A-1) give the 8-bit sum or difference; carry takes the carry out of bit 7 (the borrow for the two subtractions) and auxiliary carry takes the carry or borrow out of bit 3.
- R4: Opcode 00011 gives the low 8 bits of A*B; opcode 00100 gives A/B and clears carry, except that B=0 gives 0xFF and sets carry.
- R5: Opcodes 00000 (copy A), 00111 (A AND B), 01000 (A OR B), 01010 (A XOR B) and 01001 (NOT A) give the bitwise result.
- R6: Opcodes 10000 and 10010 shift A left with zero fill, 10001 shifts A right copying bit 7, 10011 shifts A right with zero fill, each by the 3-bit amount; an amount of 0 returns A unchanged.
- R7: Opcode 10100 rotates A left and 10101 rotates A right by the 3-bit amount.
- R8: Every computing opcode sets zero when its result is 0x00 and parity when its result holds an even number of ones.
- R9: Carry and auxiliary carry change only under R3 and R4 (divide changes carry only); non-computing opcodes and idle cycles change no flag.
- R10: Opcode 01101 always reports branchTaken; branchTarget shows the address given with every accepted operation.
- R11: Opcodes 01110, 10110, 10111 and 11000 report branchTaken when the registered zero, carry, auxiliary or parity flag, respectively, is set before the branch is accepted.
- R12: Opcode 11111 raises halt for one cycle with writeEn and branchTaken low.
- R13: Every non-computing opcode (load 01011, store 01100, jumps, branches, halt, unused codes) puts operand A on result with writeEn low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | An operation is presented this cycle |
| opcode | input | 5 | Operation code |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| shiftAmt | input | 3 | Shift or rotate distance |
| jumpTarget | input | 6 | Instruction address for jumps and branches |
| outValid | output | 1 | Result of last cycle's operation is shown |
| result | output | 8 | Computed value or carried operand A |
| writeEn | output | 1 | Result should be written to the register file |
| flagZero | output | 1 | Registered zero flag |
| flagCarry | output | 1 | Registered carry / borrow flag |
| flagAux | output | 1 | Registered auxiliary carry flag |
| flagParity | output | 1 | Registered even-parity flag |
| branchTaken | output | 1 | Control transfer to branchTarget |
| branchTarget | output | 6 | Target address of the last accepted operation |
| halt | output | 1 | Halt opcode was executed |

## Verification
The assertions assume that opcode, operands, shift amount and target are stable and known whenever inValid is high, and that reset is held for at least one clock edge before operations arrive. The stimulus changes inputs only on the falling edge, drives inValid low during reset, and inserts idle cycles between bursts so that flags must persist across gaps. It covers carry and half-carry boundaries, divide by zero, shift amounts 0 and 7 and every branch kind with its flag both set and cleared.

// File: rtl/alu8Pkg.sv
package alu8Pkg;

  typedef enum logic [4:0] {
    OP_MOV   = 5'b00000,
    OP_ADD   = 5'b00001,
    OP_SUB   = 5'b00010,
    OP_MUL   = 5'b00011,
    OP_DIV   = 5'b00100,
    OP_INC   = 5'b00101,
    OP_DEC   = 5'b00110,
    OP_AND   = 5'b00111,
    OP_OR    = 5'b01000,
    OP_NOT   = 5'b01001,
    OP_XOR   = 5'b01010,
    OP_LOAD  = 5'b01011,
    OP_STORE = 5'b01100,
    OP_JMP   = 5'b01101,
    OP_BZ    = 5'b01110,
    OP_ASL   = 5'b10000,
    OP_ASR   = 5'b10001,
    OP_LSL   = 5'b10010,
    OP_LSR   = 5'b10011,
    OP_ROL   = 5'b10100,
    OP_ROR   = 5'b10101,
    OP_BC    = 5'b10110,
    OP_BA    = 5'b10111,
    OP_BP    = 5'b11000,
    OP_HALT  = 5'b11111
  } opcode_e;

  // branch condition selector
  localparam logic [1:0] COND_Z = 2'd0;
  localparam logic [1:0] COND_C = 2'd1;
  localparam logic [1:0] COND_A = 2'd2;
  localparam logic [1:0] COND_P = 2'd3;

  typedef struct packed {
    logic z;
    logic c;
    logic a;
    logic p;
  } flags_t;

  typedef struct packed {
    logic       updZP;     // zero and parity take the new result
    logic       updArith;  // carry and aux take adder outputs
    logic       updDiv;    // carry takes divide-by-zero
    logic       writes;    // result goes to the register file
    logic       isJump;
    logic       isBranch;
    logic [1:0] condSel;
    logic       isHalt;
  } ctrl_t;

endpackage

// File: rtl/alu8Datapath.sv
module alu8Datapath
  import alu8Pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SH_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [4:0]        opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SH_W-1:0]   shiftAmt,
  input  ctrl_t             ctrl,
  output logic [DATA_W-1:0] result,
  output flags_t            flags
);

  localparam int NIB_W  = 4;
  localparam int PROD_W = 2 * DATA_W;

  logic              doSub;
  logic [DATA_W-1:0] arithB;
  logic [DATA_W:0]   wideSum;
  logic [NIB_W:0]    nibSum;
  logic [PROD_W-1:0] product;
  logic [PROD_W-1:0] rolTmp;
  logic [PROD_W-1:0] rorTmp;
  logic              divZero;
  logic [DATA_W-1:0] nextRes;

  assign doSub  = (opcode == OP_SUB) || (opcode == OP_DEC);
  assign arithB = ((opcode == OP_INC) || (opcode == OP_DEC)) ? DATA_W'(1) : opB;

  always_comb begin
    if (doSub) begin
      wideSum = {1'b0, opA} - {1'b0, arithB};
      nibSum  = {1'b0, opA[NIB_W-1:0]} - {1'b0, arithB[NIB_W-1:0]};
    end else begin
      wideSum = {1'b0, opA} + {1'b0, arithB};
      nibSum  = {1'b0, opA[NIB_W-1:0]} + {1'b0, arithB[NIB_W-1:0]};
    end
  end

  assign product = {{DATA_W{1'b0}}, opA} * {{DATA_W{1'b0}}, opB};
  assign rolTmp  = {opA, opA} << shiftAmt;
  assign rorTmp  = {opA, opA} >> shiftAmt;
  assign divZero = (opB == '0);

  always_comb begin
    case (opcode)
      OP_MOV:                  nextRes = opA;
      OP_ADD, OP_SUB,
      OP_INC, OP_DEC:          nextRes = wideSum[DATA_W-1:0];
      OP_MUL:                  nextRes = product[DATA_W-1:0];
      OP_DIV:                  nextRes = divZero ? '1 : opA / opB;
      OP_AND:                  nextRes = opA & opB;
      OP_OR:                   nextRes = opA | opB;
      OP_NOT:                  nextRes = ~opA;
      OP_XOR:                  nextRes = opA ^ opB;
      OP_ASL, OP_LSL:          nextRes = opA << shiftAmt;
      OP_ASR:                  nextRes = $unsigned($signed(opA) >>> shiftAmt);
      OP_LSR:                  nextRes = opA >> shiftAmt;
      OP_ROL:                  nextRes = rolTmp[PROD_W-1:DATA_W];
      OP_ROR:                  nextRes = rorTmp[DATA_W-1:0];
      default:                 nextRes = opA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      flags  <= '0;
    end else if (inValid) begin
      result <= nextRes;
      if (ctrl.updZP) begin
        flags.z <= (nextRes == '0);
        flags.p <= ~^nextRes;
      end
      if (ctrl.updArith) begin
        flags.c <= wideSum[DATA_W];
        flags.a <= nibSum[NIB_W];
      end
      if (ctrl.updDiv) begin
        flags.c <= divZero;
      end
    end
  end

  // R8: zero flag agrees with the stored result of a computing op
  assert_zero_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctrl.updZP) |=> (flags.z == (result == '0)));

  // R8: parity flag agrees with the stored result
  assert_parity_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctrl.updZP) |=> (flags.p == ~^result));

  // R9: no flag moves without a flag-writing operation
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && (ctrl.updZP || ctrl.updArith || ctrl.updDiv)) |=> $stable(flags));

  // R4: divide by zero saturates and sets carry
  assert_div_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == OP_DIV && opB == '0) |=> (result == '1 && flags.c));

endmodule

// File: rtl/alu8Ctrl.sv
module alu8Ctrl
  import alu8Pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [4:0]        opcode,
  input  logic [ADDR_W-1:0] jumpTarget,
  input  flags_t            flags,
  output ctrl_t             ctrl,
  output logic              outValid,
  output logic              writeEn,
  output logic              branchTaken,
  output logic [ADDR_W-1:0] branchTarget,
  output logic              halt
);

  logic condHit;

  always_comb begin
    ctrl = '0;
    case (opcode)
      OP_MOV, OP_MUL, OP_AND, OP_OR, OP_NOT, OP_XOR,
      OP_ASL, OP_ASR, OP_LSL, OP_LSR, OP_ROL, OP_ROR: begin
        ctrl.updZP  = 1'b1;
        ctrl.writes = 1'b1;
      end
      OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
        ctrl.updZP    = 1'b1;
        ctrl.updArith = 1'b1;
        ctrl.writes   = 1'b1;
      end
      OP_DIV: begin
        ctrl.updZP  = 1'b1;
        ctrl.updDiv = 1'b1;
        ctrl.writes = 1'b1;
      end
      OP_JMP:  ctrl.isJump = 1'b1;
      OP_BZ:   begin ctrl.isBranch = 1'b1; ctrl.condSel = COND_Z; end
      OP_BC:   begin ctrl.isBranch = 1'b1; ctrl.condSel = COND_C; end
      OP_BA:   begin ctrl.isBranch = 1'b1; ctrl.condSel = COND_A; end
      OP_BP:   begin ctrl.isBranch = 1'b1; ctrl.condSel = COND_P; end
      OP_HALT: ctrl.isHalt = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (ctrl.condSel)
      COND_Z:  condHit = flags.z;
      COND_C:  condHit = flags.c;
      COND_A:  condHit = flags.a;
      default: condHit = flags.p;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      writeEn      <= 1'b0;
      branchTaken  <= 1'b0;
      branchTarget <= '0;
      halt         <= 1'b0;
    end else begin
      outValid    <= inValid;
      writeEn     <= inValid && ctrl.writes;
      branchTaken <= inValid && (ctrl.isJump || (ctrl.isBranch && condHit));
      halt        <= inValid && ctrl.isHalt;
      if (inValid) branchTarget <= jumpTarget;
    end
  end

  // R2: valid output follows an accepted operation by one cycle
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R10: jump is always taken, to the given address
  assert_jump_taken_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == OP_JMP) |=> (branchTaken && branchTarget == $past(jumpTarget)));

  // R12: halt excludes write and branch
  assert_halt_alone_R12: assert property (@(posedge clk) disable iff (!rstN)
    halt |-> (outValid && !writeEn && !branchTaken));

endmodule

// File: rtl/alu8Exec.sv
module alu8Exec
  import alu8Pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [4:0]        opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic [ADDR_W-1:0] jumpTarget,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              flagZero,
  output logic              flagCarry,
  output logic              flagAux,
  output logic              flagParity,
  output logic              branchTaken,
  output logic [ADDR_W-1:0] branchTarget,
  output logic              halt
);

  ctrl_t  ctrl;
  flags_t flags;

  alu8Ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .opcode       (opcode),
    .jumpTarget   (jumpTarget),
    .flags        (flags),
    .ctrl         (ctrl),
    .outValid     (outValid),
    .writeEn      (writeEn),
    .branchTaken  (branchTaken),
    .branchTarget (branchTarget),
    .halt         (halt)
  );

  alu8Datapath #(.DATA_W(DATA_W), .SH_W(SH_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opcode   (opcode),
    .opA      (opA),
    .opB      (opB),
    .shiftAmt (shiftAmt),
    .ctrl     (ctrl),
    .result   (result),
    .flags    (flags)
  );

  assign flagZero   = flags.z;
  assign flagCarry  = flags.c;
  assign flagAux    = flags.a;
  assign flagParity = flags.p;

endmodule

// File: tb/test_alu8Exec.sv
`timescale 1ns/1ps
module test_alu8Exec;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [4:0] opcode = '0;
  logic [7:0] opA = '0, opB = '0;
  logic [2:0] shiftAmt = '0;
  logic [5:0] jumpTarget = '0;
  logic       outValid, writeEn, flagZero, flagCarry, flagAux, flagParity;
  logic       branchTaken, halt;
  logic [7:0] result;
  logic [5:0] branchTarget;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] res;
    logic       we;
    logic [3:0] flg;   // {z,c,a,p}
    logic       br;
    logic [5:0] tgt;
    logic       hlt;
    string      tag;
  } exp_t;

  exp_t expQ[$];
  logic mz = 0, mc = 0, ma = 0, mp = 0;

  always #5 clk = ~clk;

  alu8Exec i_alu8Exec (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .opA(opA), .opB(opB), .shiftAmt(shiftAmt), .jumpTarget(jumpTarget),
    .outValid(outValid), .result(result), .writeEn(writeEn),
    .flagZero(flagZero), .flagCarry(flagCarry), .flagAux(flagAux),
    .flagParity(flagParity), .branchTaken(branchTaken),
    .branchTarget(branchTarget), .halt(halt)
  );

  task automatic send(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic [2:0] sh, input logic [5:0] tg, input string tag);
    exp_t e;
    logic [15:0] w;
    logic comp;
    logic [7:0] r;
    r = a;
    comp = 1'b1;
    e.br = 1'b0;
    e.hlt = 1'b0;
    case (op)
      5'h00: r = a;
      5'h01: begin w = a + b; r = w[7:0]; mc = w[8]; ma = (a[3:0] + b[3:0]) > 15; end
      5'h02: begin r = a - b; mc = a < b; ma = a[3:0] < b[3:0]; end
      5'h03: begin w = a * b; r = w[7:0]; end
      5'h04: begin r = (b == 0) ? 8'hFF : a / b; mc = (b == 0); end
      5'h05: begin r = a + 1; mc = (a == 8'hFF); ma = (a[3:0] == 4'hF); end
      5'h06: begin r = a - 1; mc = (a == 8'h00); ma = (a[3:0] == 4'h0); end
      5'h07: r = a & b;
      5'h08: r = a | b;
      5'h09: r = ~a;
      5'h0A: r = a ^ b;
      5'h10, 5'h12: r = a << sh;
      5'h11: begin r = a; for (int i = 0; i < sh; i++) r = {r[7], r[7:1]}; end
      5'h13: r = a >> sh;
      5'h14: begin r = a; for (int i = 0; i < sh; i++) r = {r[6:0], r[7]}; end
      5'h15: begin r = a; for (int i = 0; i < sh; i++) r = {r[0], r[7:1]}; end
      default: begin
        comp = 1'b0;
        r = a;
        if (op == 5'h0D) e.br = 1'b1;
        if (op == 5'h0E) e.br = mz;
        if (op == 5'h16) e.br = mc;
        if (op == 5'h17) e.br = ma;
        if (op == 5'h18) e.br = mp;
        if (op == 5'h1F) e.hlt = 1'b1;
      end
    endcase
    if (comp) begin
      mz = (r == 0);
      mp = ~^r;
    end
    e.res = r;
    e.we = comp;
    e.flg = {mz, mc, ma, mp};
    e.tgt = tg;
    e.tag = tag;
    @(negedge clk);
    opcode = op; opA = a; opB = b; shiftAmt = sh; jumpTarget = tg; inValid = 1'b1;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor: compare every produced output with the queued expectation
  always @(negedge clk) begin
    if (rstN && outValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected outValid, actual 1 expected 0");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (result !== e.res || writeEn !== e.we ||
            {flagZero, flagCarry, flagAux, flagParity} !== e.flg ||
            branchTaken !== e.br || branchTarget !== e.tgt || halt !== e.hlt) begin
          fails++;
          $display("FAIL %s: actual res=%h we=%b zcap=%b br=%b tgt=%h halt=%b expected res=%h we=%b zcap=%b br=%b tgt=%h halt=%b",
                   e.tag, result, writeEn, {flagZero, flagCarry, flagAux, flagParity},
                   branchTaken, branchTarget, halt, e.res, e.we, e.flg, e.br, e.tgt, e.hlt);
        end
      end
    end
  end

  task automatic checkQuiet(input string tag);
    checks++;
    if ({outValid, result, writeEn, flagZero, flagCarry, flagAux, flagParity,
         branchTaken, branchTarget, halt} !== '0) begin
      fails++;
      $display("FAIL %s: actual outputs not all zero (res=%h v=%b f=%b%b%b%b br=%b h=%b) expected 0",
               tag, result, outValid, flagZero, flagCarry, flagAux, flagParity, branchTaken, halt);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkQuiet("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkQuiet("R1 after release");

    // R3 arithmetic boundaries
    send(5'h01, 8'hFF, 8'h01, 0, 6'd1, "R3 add wrap");
    send(5'h01, 8'h08, 8'h08, 0, 6'd2, "R3 add aux");
    send(5'h01, 8'h12, 8'h21, 0, 6'd3, "R3 add plain");
    send(5'h02, 8'h03, 8'h05, 0, 6'd4, "R3 sub borrow");
    send(5'h02, 8'h10, 8'h01, 0, 6'd5, "R3 sub aux borrow");
    send(5'h05, 8'hFF, 8'h00, 0, 6'd6, "R3 inc wrap");
    send(5'h06, 8'h00, 8'h00, 0, 6'd7, "R3 dec wrap");
    send(5'h06, 8'h45, 8'h00, 0, 6'd8, "R3 dec plain");
    // R4 multiply / divide
    send(5'h03, 8'h10, 8'h11, 0, 6'd9, "R4 mul low byte");
    send(5'h04, 8'd200, 8'd7, 0, 6'd10, "R4 div");
    send(5'h04, 8'h5A, 8'h00, 0, 6'd11, "R4 div by zero");
    // R11 branch on carry while set, R9 via branch
    send(5'h16, 8'h00, 8'h00, 0, 6'd12, "R11 bc set");
    send(5'h04, 8'h09, 8'h03, 0, 6'd13, "R4 div clears carry");
    send(5'h16, 8'h00, 8'h00, 0, 6'd14, "R11 bc clear");
    idle(3);
    // R5 logic
    send(5'h00, 8'hA5, 8'h00, 0, 6'd15, "R5 move");
    send(5'h07, 8'hF0, 8'h3C, 0, 6'd16, "R5 and");
    send(5'h08, 8'hF0, 8'h0C, 0, 6'd17, "R5 or");
    send(5'h0A, 8'hFF, 8'hFF, 0, 6'd18, "R5 xor zero");
    send(5'h09, 8'h0F, 8'h00, 0, 6'd19, "R5 not");
    // R6 shifts
    send(5'h10, 8'h81, 8'h00, 3'd1, 6'd20, "R6 asl");
    send(5'h11, 8'h80, 8'h00, 3'd7, 6'd21, "R6 asr sign");
    send(5'h11, 8'h40, 8'h00, 3'd2, 6'd22, "R6 asr pos");
    send(5'h12, 8'hFF, 8'h00, 3'd7, 6'd23, "R6 lsl 7");
    send(5'h13, 8'h80, 8'h00, 3'd7, 6'd24, "R6 lsr 7");
    send(5'h13, 8'h96, 8'h00, 3'd0, 6'd25, "R6 shift amount 0");
    // R7 rotates
    send(5'h14, 8'h81, 8'h00, 3'd1, 6'd26, "R7 rol");
    send(5'h15, 8'h81, 8'h00, 3'd3, 6'd27, "R7 ror");
    send(5'h14, 8'h3C, 8'h00, 3'd0, 6'd28, "R7 rol 0");
    idle(2);
    // R8/R11 flag-conditioned branches both ways
    send(5'h07, 8'h0F, 8'hF0, 0, 6'd29, "R8 zero result");
    send(5'h0E, 8'h11, 8'h00, 0, 6'd30, "R11 bz set");
    send(5'h18, 8'h12, 8'h00, 0, 6'd31, "R11 bp set");
    send(5'h00, 8'h01, 8'h00, 0, 6'd32, "R8 odd parity");
    send(5'h0E, 8'h13, 8'h00, 0, 6'd33, "R11 bz clear");
    send(5'h18, 8'h14, 8'h00, 0, 6'd34, "R11 bp clear");
    send(5'h01, 8'h0F, 8'h01, 0, 6'd35, "R3 aux set");
    send(5'h17, 8'h15, 8'h00, 0, 6'd36, "R11 ba set");
    send(5'h01, 8'h01, 8'h01, 0, 6'd37, "R3 aux clear");
    send(5'h17, 8'h16, 8'h00, 0, 6'd38, "R11 ba clear");
    // R10 jump, R13 pass-through, R9 flags kept
    send(5'h0D, 8'h77, 8'h00, 0, 6'd63, "R10 jump");
    send(5'h0B, 8'h5C, 8'h00, 0, 6'd39, "R13 load");
    send(5'h0C, 8'hC5, 8'h00, 0, 6'd40, "R13 store");
    send(5'h0F, 8'h00, 8'hFF, 0, 6'd41, "R13 unused code");
    send(5'h1B, 8'h33, 8'h00, 0, 6'd42, "R9 unused code keeps flags");
    send(5'h03, 8'hFF, 8'hFF, 0, 6'd43, "R9 mul keeps carry aux");
    send(5'h1F, 8'h66, 8'h00, 0, 6'd44, "R12 halt");
    send(5'h01, 8'h02, 8'h03, 0, 6'd45, "R2 after halt");
    idle(4);

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R2: actual %0d results missing expected 0", expQ.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule